// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block is the master-side bit engine for a three-wire link made of a chip-enable, a serial clock and one bidirectional data line. A caller pulses `start` with a direction select. In transmit mode it supplies a byte, and the block shifts that byte out. In receive mode the block clocks a byte in from the slave. When the eighth bit ends, the block raises `done` for one cycle.

The serial clock rests high. Each bit is a high phase followed by a low phase. Each phase lasts a fixed number of system cycles. That number is derived from the system clock frequency and a minimum phase time, 700 ns by default. The slave latches transmitted data on the rising serial-clock edge. The incoming data is synchronised and then sampled as the clock falls. Only the low four bits of a received byte are kept.

The chip-enable is not sequenced by the engine. The caller drives it, and the block passes it to the pin one register later. Command encoding and register meaning belong to the caller.

Top module: `tw_shifter`

## Requirements
- R1: A transfer moves exactly 8 bits, most significant bit first. In transmit mode the value on `link_sdo` during bit j (j = 0..7) equals `tx_byte[7-j]` as captured on the accepting edge.
- R2: `link_sclk` is high whenever no transfer runs. Each bit is a high phase of H cycles followed by a low phase of H cycles. H = ceil(CLK_HZ x MIN_PHASE_NS / 1e9), which is 175 cycles at 250 MHz and 700 ns.
- R3: In transmit mode, a bit value is placed at the start of its high phase. The first bit is placed on the accepting edge, and later bits on the rising `link_sclk` edge that ends the previous bit. `link_sdo` does not change while `link_sclk` is low.
- R4: `link_sdo_oe` rises one cycle after the first bit is placed. It stays high until the edge that ends the last low phase, where it falls together with the rise of `done`. It is never high in receive mode.
- R5: In receive mode, the data input passes through a two-stage synchronizer. It is sampled on the edge where `link_sclk` falls, and the bits are assembled most significant first.
- R6: After a receive, `rx_byte[7:4]` is 0 and `rx_byte[3:0]` holds the last four sampled bits. A transmit leaves `rx_byte` unchanged.
- R7: `busy` is high from the accepting edge until `done`. `done` is a one-cycle pulse 16·H cycles after the accepting edge, in the same cycle that `busy` falls.
- R8: A `start` seen while `busy` is high, including in the last busy cycle, is ignored. It changes neither the running transfer, nor its timing, nor its mode, and it does not begin a new transfer.
- R9: `link_ce` equals `ce_req` delayed by one cycle, and it is low while reset is applied.
- R10: After a synchronous active-low reset: `link_sclk`=1, `link_sdo_oe`=0, `busy`=0, `done`=0, `link_ce`=0, `rx_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| rx_sel | input | 1 | 1 = receive a byte, 0 = transmit |
| tx_byte | input | 8 | Byte to transmit |
| ce_req | input | 1 | Caller's chip-enable request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Received byte, upper nibble zero |
| link_ce | output | 1 | Chip-enable pin, active high |
| link_sclk | output | 1 | Serial clock pin, idles high |
| link_sdo | output | 1 | Data value driven onto the line |
| link_sdo_oe | output | 1 | Data line driver enable |
| link_sdi | input | 1 | Data value read from the line |

## Verification
The hardest case to produce from the ports is a `start` that arrives in the final busy cycle. At that point the transfer is one edge from finishing and the engine is about to go idle, so a slip of one cycle would launch an unwanted second transfer. The stimulus injects stray starts with the opposite mode and a different byte at chosen offsets, including that last cycle. The bench then checks that the running bit pattern, the `done` time and the idle state after `done` are unchanged. Receive data is changed one half period before each sample edge, so a wrong synchronizer depth or a wrong sample edge shows up as wrong nibbles.

// File: rtl/tw_pkg.sv
// Shared types and helpers for the three-wire shifter.
// Assumes: caller passes frequency in Hz and minimum phase time in ns.
package tw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } tw_phase_e;

    // Smallest cycle count whose duration covers the requested phase time.
    function automatic int half_cycles(longint hz, longint ns);
        longint prod;
        longint q;
        prod = hz * ns;
        q    = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        return (q < 1) ? 1 : int'(q);
    endfunction

endpackage

// File: rtl/tw_sync.sv
// Multi-stage synchronizer for the serial data input.
// Assumes: STAGES >= 2; the output lags the input by STAGES clocks.
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_phase_timer.sv
// Half-period timer: counts while run is high, ticks on the last cycle
// of each phase and restarts by itself.
// Assumes: HALF >= 1; clr restarts the count at the start of a transfer.
module tw_phase_timer #(
    parameter int HALF = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count cycles inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else if (run)              cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                                    // R2
endmodule

// File: rtl/tw_shift_fsm.sv
// Bit sequencer: builds the serial clock, shifts transmit data MSB first,
// gates the data driver and assembles the received nibble.
// Assumes: tick marks the last cycle of each phase; sdi_s is synchronised.
module tw_shift_fsm #(
    parameter int DATA_W = 8,
    parameter int KEEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rx_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tick,
    input  logic              sdi_s,
    output logic              run,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe
);
    import tw_pkg::*;

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << KEEP_W) - 1);

    tw_phase_e         phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic              rx_mode;

    assign run    = (phase != PH_IDLE);
    assign busy   = run;
    assign accept = (phase == PH_IDLE) && start;

    // Phase sequencing, shifting and pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rx_mode <= 1'b0;
            sclk    <= 1'b1;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
            done    <= 1'b0;
            rx_data <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_HIGH;
                        rx_mode <= rx_sel;
                        shreg   <= tx_data;
                        sdo     <= tx_data[DATA_W-1] & ~rx_sel;
                        bit_cnt <= LAST_BIT;
                    end
                end
                PH_HIGH: begin
                    if (!rx_mode) sdo_oe <= 1'b1;
                    if (tick) begin
                        sclk  <= 1'b0;
                        phase <= PH_LOW;
                        if (rx_mode) shreg <= {shreg[DATA_W-2:0], sdi_s};
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        if (bit_cnt == '0) begin
                            phase  <= PH_IDLE;
                            sdo_oe <= 1'b0;
                            done   <= 1'b1;
                            if (rx_mode) rx_data <= shreg & KEEP_MASK;
                        end else begin
                            bit_cnt <= bit_cnt - 1'b1;
                            phase   <= PH_HIGH;
                            if (!rx_mode) begin
                                shreg <= {shreg[DATA_W-2:0], 1'b0};
                                sdo   <= shreg[DATA_W-2];
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);                                                 // R2
    AST_SDO_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> $stable(sdo));                                         // R3
    AST_OE_TX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (busy && !rx_mode));                                  // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                 // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (rx_mode == $past(rx_mode)));                // R8
endmodule

// File: rtl/tw_shifter.sv
// Three-wire master byte shifter top: ties the synchronizer, phase timer
// and sequencer together and registers the caller's chip-enable.
// Assumes: clk runs at CLK_HZ; the pad logic combines sdo and sdo_oe.
module tw_shifter #(
    parameter int unsigned CLK_HZ       = 250_000_000,
    parameter int unsigned MIN_PHASE_NS = 700,
    parameter int          DATA_W       = 8,
    parameter int          KEEP_W       = 4,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rx_sel,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ce_req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              link_ce,
    output logic              link_sclk,
    output logic              link_sdo,
    output logic              link_sdo_oe,
    input  logic              link_sdi
);
    localparam int HALF = tw_pkg::half_cycles(longint'(CLK_HZ), longint'(MIN_PHASE_NS));

    logic sdi_s;
    logic tick;
    logic run;
    logic accept;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(link_sdi), .q(sdi_s)
    );

    tw_phase_timer #(.HALF(HALF)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(accept), .tick(tick)
    );

    tw_shift_fsm #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_sel(rx_sel),
        .tx_data(tx_byte), .tick(tick), .sdi_s(sdi_s), .run(run),
        .accept(accept), .busy(busy), .done(done), .rx_data(rx_byte),
        .sclk(link_sclk), .sdo(link_sdo), .sdo_oe(link_sdo_oe)
    );

    // Register the caller's chip-enable onto the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) link_ce <= 1'b0;
        else        link_ce <= ce_req;
    end

    AST_CE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (link_ce == $past(ce_req)));                    // R9
    AST_RX_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rx_byte[DATA_W-1:KEEP_W] == '0));                      // R6
endmodule

// File: tb/tw_shifter_test.sv
`timescale 1ns/1ps
module tw_shifter_test;
    localparam int H = 175;   // ceil(250e6 * 700e-9): cycles per phase (R2)
    localparam int FULL = 16 * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rx_sel = 1'b0;
    logic [7:0] tx_byte = '0;
    logic ce_req = 1'b0;
    logic link_sdi = 1'b0;
    logic busy, done, link_ce, link_sclk, link_sdo, link_sdo_oe;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;
    logic [7:0] last_rx = 8'h00;
    logic ce_prev = 1'b0;

    always #2 clk = ~clk;

    tw_shifter uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_sel(rx_sel),
        .tx_byte(tx_byte), .ce_req(ce_req), .busy(busy), .done(done),
        .rx_byte(rx_byte), .link_ce(link_ce), .link_sclk(link_sclk),
        .link_sdo(link_sdo), .link_sdo_oe(link_sdo_oe), .link_sdi(link_sdi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Expected receive result: upper nibble cleared (R6).
    function automatic logic [7:0] nib(input logic [7:0] b);
        return {4'h0, b[3:0]};
    endfunction

    // One transfer, checked every cycle against the requirement timeline.
    // inj >= 0 places a stray start (opposite mode, other byte) at that sample.
    task automatic run_xfer(input bit rx, input logic [7:0] txb,
                            input logic [7:0] slv, input int inj);
        rx_sel   = rx;
        tx_byte  = txb;
        link_sdi = slv[7];
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        tx_byte = ~txb;
        for (int s = 0; s <= FULL + 2; s++) begin
            int  bi;
            bit  inx;
            bit  e_sclk;
            bi     = s / (2 * H);
            inx    = (s < FULL);
            e_sclk = inx ? ((s % (2 * H)) < H) : 1'b1;
            chk(link_sclk == e_sclk, "R2", "sclk", link_sclk, e_sclk);
            chk(busy == inx, "R7", "busy", busy, inx);
            chk(done == (s == FULL), "R7", "done", done, (s == FULL));
            chk(link_sdo_oe == (!rx && inx && s >= 1), "R4", "oe",
                link_sdo_oe, (!rx && inx && s >= 1));
            if (!rx && inx)
                chk(link_sdo == txb[7 - bi], "R1", "sdo bit", link_sdo, txb[7 - bi]);
            if (!rx && inx && !e_sclk)
                chk(link_sdo == txb[7 - bi], "R3", "sdo hold low", link_sdo, txb[7 - bi]);
            if (s == FULL) begin
                if (rx) begin
                    chk(rx_byte == nib(slv), "R5", "rx data", rx_byte, nib(slv));
                    chk(rx_byte[7:4] == 4'h0, "R6", "rx upper", rx_byte[7:4], 0);
                    last_rx = nib(slv);
                end else begin
                    chk(rx_byte == last_rx, "R6", "rx kept", rx_byte, last_rx);
                end
            end
            if (inj >= 0 && s > inj)
                chk(busy == inx, "R8", "stray start", busy, inx);
            chk(link_ce == ce_prev, "R9", "ce follow", link_ce, ce_prev);
            // drive next inputs
            if (rx && inx) link_sdi = slv[7 - bi];
            if (s == inj) begin
                start   = 1'b1;
                rx_sel  = ~rx;
                tx_byte = ~txb ^ 8'h3c;
            end else begin
                start  = 1'b0;
                rx_sel = rx;
            end
            ce_req  = $urandom_range(0, 1);
            ce_prev = ce_req;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h00c0ffee));
        ce_req = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state; R9 chip-enable held low during reset
        chk(link_sclk == 1'b1, "R10", "sclk", link_sclk, 1);
        chk(link_sdo_oe == 1'b0, "R10", "oe", link_sdo_oe, 0);
        chk(busy == 1'b0, "R10", "busy", busy, 0);
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(rx_byte == 8'h00, "R10", "rx_byte", rx_byte, 0);
        chk(link_ce == 1'b0, "R9", "ce in reset", link_ce, 0);
        rst_n = 1'b1;
        ce_req = 1'b0;
        @(negedge clk);
        ce_prev = 1'b0;
        // directed transmit patterns (R1 R3 R4)
        run_xfer(1'b0, 8'hA5, 8'h00, -1);
        run_xfer(1'b0, 8'h00, 8'h00, -1);
        run_xfer(1'b0, 8'hFF, 8'h00, -1);
        run_xfer(1'b0, 8'h80, 8'h00, -1);
        run_xfer(1'b0, 8'h01, 8'h00, -1);
        // directed receive patterns (R5 R6)
        run_xfer(1'b1, 8'h00, 8'hFF, -1);
        run_xfer(1'b1, 8'h00, 8'hA6, -1);
        run_xfer(1'b1, 8'h00, 8'h50, -1);
        run_xfer(1'b0, 8'h3C, 8'h00, -1);   // R6: transmit keeps rx_byte
        // stray starts (R8): mid transfer and in the last busy cycle
        run_xfer(1'b0, 8'hC3, 8'h00, 3 * H + 7);
        run_xfer(1'b0, 8'h5A, 8'h00, FULL - 1);
        run_xfer(1'b1, 8'h00, 8'h9D, FULL - 1);
        run_xfer(1'b1, 8'h00, 8'h72, 1);
        // random mix
        for (int k = 0; k < 10; k++) begin
            bit   r;
            logic [7:0] a;
            logic [7:0] b;
            int   inj;
            r   = $urandom_range(0, 1);
            a   = 8'($urandom);
            b   = 8'($urandom);
            inj = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, FULL - 1)) : -1;
            run_xfer(r, a, b, inj);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule